// File: doc/BRIEF.md
# Alternating Two-Buffer Character Stager

This block stages characters between a tape-style device that moves one 6-bit character at a time and a memory port that moves five characters per access. It has two five-slot buffers, A and B. Each buffer has a position digit and a full flag. A selector bit names the buffer currently in use by the device side. The direction of a transfer is fixed when the transfer starts.

On device input, characters collect in the selected buffer. A completed buffer is written to memory as one five-character word. On device output, memory loads whole buffers and the device takes them out one character at a time. An end-of-record mark on input closes a partly filled buffer with group-mark padding, so that it can be written out. The memory address starts at the value given at transfer start and advances by the slot count after every grant.

Top module: `ppbuf_pair`

## Requirements
- R1: After reset, and in the cycle after `xfer_start`, both buffers are empty with their position digits at 10 (10 means position 0), and the selector points at A. `mem_addr` equals `xfer_addr` after a start and 0 after reset. After reset the direction is input.
- R2: On input, each accepted character is stored in the next slot of the active buffer, starting at slot 0. When slot 4 is written, that buffer becomes full and the selector moves to the other buffer. In `mem_wdata`, slot i sits in bits [6i+5:6i].
- R3: An input character equal to 0 is stored as octal 20.
- R4: An input character offered while both buffers are full is refused. `din_ready` is low, `din_terr` is high, and the character is not stored.
- R5: On input, `mem_req` with `mem_we` high is asserted whenever a buffer is full. Buffer A is written before B. Each grant empties the buffer written and raises `mem_addr` by 5.
- R6: `rec_end` on input pads a partly filled active buffer with group marks (octal 77) in all slots from its position through slot 4, and marks it full. The selector is left unchanged. With the active buffer empty, `rec_end` has no effect. `rec_end` is never raised in the same cycle as `din_valid`.
- R7: On output, `mem_req` with `mem_we` low is asserted while a buffer is not full and `load_stop` is low. Each grant loads `mem_rdata` into A if A is not full, otherwise into B, and raises `mem_addr` by 5. Device requests return slots 0 to 4 of the active buffer in turn; the fifth empties it and moves the selector.
- R8: An output request with both buffers empty returns `dout_terr` when `load_stop` is low and `dout_eor` when it is high. At most one of `dout_valid`, `dout_terr` and `dout_eor` is high at a time.
- R9: If the selected buffer is not in the state an operation needs (full for a fill, empty for a drain), the operation uses the other buffer and the selector follows it.
- R10: On output, the blank code (octal 20) is presented on `dout_data` as the alternate blank (octal 60).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Begin a transfer: empty both buffers, load address and direction |
| xfer_dir_in | input | 1 | Direction sampled at start: 1 = device to memory, 0 = memory to device |
| xfer_addr | input | AW | First memory address of the transfer |
| load_stop | input | 1 | Output: no more memory loads; an empty drain reports end of record |
| din_valid | input | 1 | Device offers an input character |
| din_data | input | CW | Input character |
| din_ready | output | 1 | Offered character is accepted this cycle |
| din_terr | output | 1 | Offered character refused, both buffers full |
| rec_end | input | 1 | End of the input record |
| dout_req | input | 1 | Device asks for an output character |
| dout_valid | output | 1 | A character is returned on `dout_data` |
| dout_data | output | CW | Output character |
| dout_terr | output | 1 | Request refused, no data and no stop |
| dout_eor | output | 1 | Request answered with end of record |
| mem_req | output | 1 | Memory access wanted |
| mem_we | output | 1 | 1 = write `mem_wdata`, 0 = read into a buffer |
| mem_addr | output | AW | Address of the first of the five characters |
| mem_wdata | output | SLOTS*CW | Five characters to write |
| mem_rdata | input | SLOTS*CW | Five characters read, valid with the grant |
| mem_gnt | input | 1 | Access taken this cycle |

## Verification
The hardest case to reach is the resynchronising flip on input. The selector only points at a full buffer after an end-of-record pad, because padding fills a buffer without moving the selector. The stimulus fills A, starts B, and pads B with `rec_end`. It then lets memory empty A and offers one more character. That character must land in slot 0 of A, and the next words must leave memory in the order A then B.

// File: rtl/ppbuf_pkg.sv
// Shared definitions for the two-buffer character stager.
// Assumes a position digit of four bits whose value 10 stands for "empty".
package ppbuf_pkg;
    localparam int POS_W = 4;
    typedef logic [POS_W-1:0] pos_t;
    localparam pos_t POS_EMPTY = pos_t'(10);
endpackage

// File: rtl/ppbuf_bank.sv
// One character buffer: SLOTS character slots, a position digit and a full flag.
// Assumes the controller never asks to put into, or load, a full buffer, and never
// asks to take from, or unload, an empty one. SLOTS must be below 10.
module ppbuf_bank
    import ppbuf_pkg::*;
#(
    parameter int             CW      = 6,
    parameter int             SLOTS   = 5,
    parameter logic [CW-1:0]  GM_CODE = 6'o77
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                put,
    input  logic [CW-1:0]       put_ch,
    input  logic                take,
    input  logic                pad,
    input  logic                load,
    input  logic [SLOTS*CW-1:0] load_word,
    input  logic                unload,
    output logic [SLOTS*CW-1:0] word,
    output logic [CW-1:0]       cur_ch,
    output logic                full,
    output logic                at_last
);
    localparam pos_t LAST_POS = pos_t'(SLOTS - 1);

    pos_t          pos_q;
    pos_t          cur;
    logic          full_q;
    logic          pad_ok;
    logic [CW-1:0] slot_q [SLOTS];

    // Effective slot index: the empty code means slot 0.
    assign cur     = (pos_q == POS_EMPTY) ? '0 : pos_q;
    assign at_last = (cur == LAST_POS);
    assign full    = full_q;
    assign pad_ok  = pad && (pos_q != POS_EMPTY) && !full_q;

    // Present the slots as one memory word, slot 0 in the low bits.
    for (genvar g = 0; g < SLOTS; g++) begin : g_pack
        assign word[g*CW +: CW] = slot_q[g];
    end

    // Pick the character at the current position.
    always_comb begin
        cur_ch = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (cur == pos_t'(i)) cur_ch = slot_q[i];
        end
    end

    // Track the position digit and the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_q  <= POS_EMPTY;
            full_q <= 1'b0;
        end else if (load) begin
            pos_q  <= POS_EMPTY;
            full_q <= 1'b1;
        end else if (unload) begin
            pos_q  <= POS_EMPTY;
            full_q <= 1'b0;
        end else if (put) begin
            pos_q <= cur + pos_t'(1);
            if (at_last) full_q <= 1'b1;
        end else if (take) begin
            pos_q <= cur + pos_t'(1);
            if (at_last) full_q <= 1'b0;
        end else if (pad_ok) begin
            pos_q  <= pos_t'(SLOTS);
            full_q <= 1'b1;
        end
    end

    // Update the character slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_q[i];
        end else if (load) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= load_word[i*CW +: CW];
        end else if (put) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (cur == pos_t'(i)) slot_q[i] <= put_ch;
            end
        end else if (pad_ok) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (pos_t'(i) >= cur) slot_q[i] <= GM_CODE;
            end
        end
    end
endmodule

// File: rtl/ppbuf_steer.sv
// Device-side steering: chooses the buffer for each character operation,
// resynchronises the selector and forms the device responses.
// Assumes direction is stable between transfer starts. Purely combinational.
module ppbuf_steer (
    input  logic       dir_in,
    input  logic       sel_q,
    input  logic [1:0] full,
    input  logic [1:0] last,
    input  logic       din_valid,
    input  logic       dout_req,
    input  logic       rec_end,
    input  logic       load_stop,
    output logic [1:0] put,
    output logic [1:0] take,
    output logic [1:0] pad,
    output logic       sel_d,
    output logic       use_b,
    output logic       din_ready,
    output logic       din_terr,
    output logic       dout_valid,
    output logic       dout_terr,
    output logic       dout_eor
);
    logic room, avail, fill_b, drain_b, do_put, do_take, last_used;

    // Decide the target buffer, with the flip to the other one when needed.
    always_comb begin
        room      = !(full[0] && full[1]);
        avail     = full[0] || full[1];
        fill_b    = sel_q ? !full[1] : full[0];
        drain_b   = sel_q ? full[1] : !full[0];
        use_b     = dir_in ? fill_b : drain_b;
        do_put    = dir_in && din_valid && room;
        do_take   = !dir_in && dout_req && avail;
        last_used = use_b ? last[1] : last[0];
        sel_d     = (do_put || do_take) ? (use_b ^ last_used) : sel_q;
    end

    // Per-buffer strobes and device responses.
    always_comb begin
        put        = {do_put && use_b, do_put && !use_b};
        take       = {do_take && use_b, do_take && !use_b};
        pad        = {rec_end && dir_in && sel_q, rec_end && dir_in && !sel_q};
        din_ready  = dir_in && room;
        din_terr   = dir_in && din_valid && !room;
        dout_valid = do_take;
        dout_terr  = !dir_in && dout_req && !avail && !load_stop;
        dout_eor   = !dir_in && dout_req && !avail && load_stop;
    end
endmodule

// File: rtl/ppbuf_memport.sv
// Memory-side port: requests word transfers, always serving A before B,
// and keeps the address counter that moves by SLOTS per grant.
// Assumes mem_rdata is valid in the cycle mem_gnt is high.
module ppbuf_memport #(
    parameter int CW    = 6,
    parameter int SLOTS = 5,
    parameter int AW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [AW-1:0]       start_addr,
    input  logic                dir_in,
    input  logic                load_stop,
    input  logic [1:0]          full,
    input  logic [SLOTS*CW-1:0] word_a,
    input  logic [SLOTS*CW-1:0] word_b,
    input  logic                mem_gnt,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [SLOTS*CW-1:0] mem_wdata,
    output logic [1:0]          load,
    output logic [1:0]          unload
);
    logic          pick_b, go;
    logic [AW-1:0] addr_q;

    // Choose the buffer to move and whether to ask at all.
    always_comb begin
        pick_b    = dir_in ? !full[0] : full[0];
        mem_req   = dir_in ? (full[0] || full[1])
                           : (!load_stop && !(full[0] && full[1]));
        mem_we    = dir_in;
        go        = mem_req && mem_gnt && !clr;
        mem_wdata = pick_b ? word_b : word_a;
        unload    = {go && dir_in && pick_b, go && dir_in && !pick_b};
        load      = {go && !dir_in && pick_b, go && !dir_in && !pick_b};
    end

    assign mem_addr = addr_q;

    // Address counter: loaded at start, advanced per granted word.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (clr)   addr_q <= start_addr;
        else if (go)    addr_q <= addr_q + AW'(SLOTS);
    end
endmodule

// File: rtl/ppbuf_pair.sv
// Two alternating character buffers between a character device and a word memory.
// Holds the selector and direction, converts codes at the device edge, and
// wires two banks, the steering logic and the memory port together.
// Assumes rec_end never coincides with din_valid.
module ppbuf_pair #(
    parameter int            CW         = 6,
    parameter int            SLOTS      = 5,
    parameter int            AW         = 16,
    parameter logic [CW-1:0] ZERO_SUB   = 6'o20,
    parameter logic [CW-1:0] BLANK_CODE = 6'o20,
    parameter logic [CW-1:0] ALT_BLANK  = 6'o60,
    parameter logic [CW-1:0] GM_CODE    = 6'o77
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_start,
    input  logic                xfer_dir_in,
    input  logic [AW-1:0]       xfer_addr,
    input  logic                load_stop,
    input  logic                din_valid,
    input  logic [CW-1:0]       din_data,
    output logic                din_ready,
    output logic                din_terr,
    input  logic                rec_end,
    input  logic                dout_req,
    output logic                dout_valid,
    output logic [CW-1:0]       dout_data,
    output logic                dout_terr,
    output logic                dout_eor,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [SLOTS*CW-1:0] mem_wdata,
    input  logic [SLOTS*CW-1:0] mem_rdata,
    input  logic                mem_gnt
);
    logic                sel_q, sel_d, dir_q, use_b;
    logic [1:0]          full, last, put, take, pad, load, unload;
    logic [SLOTS*CW-1:0] word [2];
    logic [CW-1:0]       cur_ch [2];
    logic [CW-1:0]       put_ch, rd_ch;

    // Selector and latched direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            dir_q <= 1'b1;
        end else if (xfer_start) begin
            sel_q <= 1'b0;
            dir_q <= xfer_dir_in;
        end else begin
            sel_q <= sel_d;
        end
    end

    // Code substitution at the device edge.
    always_comb begin
        put_ch    = (din_data == '0) ? ZERO_SUB : din_data;
        rd_ch     = use_b ? cur_ch[1] : cur_ch[0];
        dout_data = (rd_ch == BLANK_CODE) ? ALT_BLANK : rd_ch;
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        ppbuf_bank #(.CW(CW), .SLOTS(SLOTS), .GM_CODE(GM_CODE)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (xfer_start),
            .put       (put[g]),
            .put_ch    (put_ch),
            .take      (take[g]),
            .pad       (pad[g]),
            .load      (load[g]),
            .load_word (mem_rdata),
            .unload    (unload[g]),
            .word      (word[g]),
            .cur_ch    (cur_ch[g]),
            .full      (full[g]),
            .at_last   (last[g])
        );
    end

    ppbuf_steer u_steer (
        .dir_in     (dir_q),
        .sel_q      (sel_q),
        .full       (full),
        .last       (last),
        .din_valid  (din_valid),
        .dout_req   (dout_req),
        .rec_end    (rec_end),
        .load_stop  (load_stop),
        .put        (put),
        .take       (take),
        .pad        (pad),
        .sel_d      (sel_d),
        .use_b      (use_b),
        .din_ready  (din_ready),
        .din_terr   (din_terr),
        .dout_valid (dout_valid),
        .dout_terr  (dout_terr),
        .dout_eor   (dout_eor)
    );

    ppbuf_memport #(.CW(CW), .SLOTS(SLOTS), .AW(AW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (xfer_start),
        .start_addr (xfer_addr),
        .dir_in     (dir_q),
        .load_stop  (load_stop),
        .full       (full),
        .word_a     (word[0]),
        .word_b     (word[1]),
        .mem_gnt    (mem_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .load       (load),
        .unload     (unload)
    );
endmodule

// File: rtl/ppbuf_pair_chk.sv
// Property checker for ppbuf_pair, attached by bind. Observes only.
module ppbuf_pair_chk #(
    parameter int SLOTS = 5,
    parameter int AW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic          din_valid,
    input logic          din_ready,
    input logic          din_terr,
    input logic          rec_end,
    input logic          dout_valid,
    input logic          dout_terr,
    input logic          dout_eor,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    full,
    input logic [1:0]    last,
    input logic [1:0]    put,
    input logic [1:0]    take,
    input logic          sel_q
);
    AST_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (full == 2'b00) && !sel_q); // R1
    AST_FILL_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (put[0] && last[0] && !xfer_start) |=> full[0] && sel_q); // R2
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (din_terr && !mem_gnt && !xfer_start) |=> !din_ready); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !xfer_start) |=> (mem_addr == $past(mem_addr) + AW'(SLOTS))); // R5
    AST_END_NOT_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(din_valid && rec_end)); // R6
    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take[1] && last[1] && !xfer_start) |=> !full[1]); // R7
    AST_ONE_OUT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dout_valid, dout_terr, dout_eor})); // R8
endmodule

bind ppbuf_pair ppbuf_pair_chk #(.SLOTS(SLOTS), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .din_valid  (din_valid),
    .din_ready  (din_ready),
    .din_terr   (din_terr),
    .rec_end    (rec_end),
    .dout_valid (dout_valid),
    .dout_terr  (dout_terr),
    .dout_eor   (dout_eor),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .full       (full),
    .last       (last),
    .put        (put),
    .take       (take),
    .sel_q      (sel_q)
);

// File: tb/ppbuf_pair_tb.sv
module ppbuf_pair_tb;
    localparam int CW = 6;
    localparam int SLOTS = 5;
    localparam int AW = 16;
    localparam int WW = CW * SLOTS;

    localparam logic [1:0] OP_PUT = 2'd0;
    localparam logic [1:0] OP_GNT = 2'd1;
    localparam logic [1:0] OP_END = 2'd2;

    typedef struct packed {
        logic [1:0]    op;
        logic [5:0]    ch;
        logic [WW-1:0] ex;
    } vec_t;

    function automatic logic [WW-1:0] w5(input logic [5:0] a, b, c, d, e);
        return {e, d, c, b, a};
    endfunction
    function automatic vec_t P(input logic [5:0] c, input logic rdy);
        return {OP_PUT, c, {{(WW-1){1'b0}}, rdy}};
    endfunction
    function automatic vec_t G(input logic [WW-1:0] w);
        return {OP_GNT, 6'd0, w};
    endfunction
    function automatic vec_t E();
        return {OP_END, 6'd0, {WW{1'b0}}};
    endfunction

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        P(6'd1,1), P(6'd2,1), P(6'd3,1), P(6'd4,1), P(6'd5,1),
        P(6'd0,1), P(6'd7,1), P(6'd8,1), P(6'd9,1), P(6'd10,1),
        P(6'd11,0),
        G(w5(6'd1,6'd2,6'd3,6'd4,6'd5)),
        G(w5(6'o20,6'd7,6'd8,6'd9,6'd10)),
        P(6'd21,1), P(6'd22,1), E(),
        G(w5(6'd21,6'd22,6'o77,6'o77,6'o77)),
        P(6'd31,1), P(6'd32,1), P(6'd33,1), P(6'd34,1), P(6'd35,1),
        P(6'd41,1), P(6'd42,1), E(),
        G(w5(6'd31,6'd32,6'd33,6'd34,6'd35)),
        P(6'd51,1), P(6'd52,1), P(6'd53,1), P(6'd54,1), P(6'd55,1),
        G(w5(6'd51,6'd52,6'd53,6'd54,6'd55)),
        G(w5(6'd41,6'd42,6'o77,6'o77,6'o77))
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 1'b0, xfer_dir_in = 1'b1, load_stop = 1'b0;
    logic [AW-1:0] xfer_addr = '0;
    logic din_valid = 1'b0, rec_end = 1'b0, dout_req = 1'b0, mem_gnt = 1'b0;
    logic [CW-1:0] din_data = '0;
    logic [WW-1:0] mem_rdata = '0;
    logic din_ready, din_terr, dout_valid, dout_terr, dout_eor, mem_req, mem_we;
    logic [CW-1:0] dout_data;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [AW-1:0] exp_addr = '0;

    always #4 clk = ~clk;

    ppbuf_pair u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir_in(xfer_dir_in),
        .xfer_addr(xfer_addr), .load_stop(load_stop), .din_valid(din_valid),
        .din_data(din_data), .din_ready(din_ready), .din_terr(din_terr),
        .rec_end(rec_end), .dout_req(dout_req), .dout_valid(dout_valid),
        .dout_data(dout_data), .dout_terr(dout_terr), .dout_eor(dout_eor),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [AW-1:0] a, input logic dir);
        @(negedge clk);
        xfer_start = 1'b1; xfer_addr = a; xfer_dir_in = dir;
        @(posedge clk); #1;
        xfer_start = 1'b0;
        exp_addr = a;
    endtask

    task automatic put_chk(input logic [5:0] c, input logic rdy);
        @(negedge clk);
        din_valid = 1'b1; din_data = c; #1;
        chk("R2 R4 din_ready", din_ready, rdy);
        if (!rdy) chk("R4 din_terr", din_terr, 1);
        @(posedge clk); #1;
        din_valid = 1'b0;
    endtask

    task automatic end_pulse();
        @(negedge clk);
        rec_end = 1'b1;
        @(posedge clk); #1;
        rec_end = 1'b0;
    endtask

    task automatic gnt_in(input logic [WW-1:0] ex);
        @(negedge clk);
        mem_gnt = 1'b1; #1;
        chk("R5 mem_req/mem_we", {mem_req, mem_we}, 2'b11);
        chk("R2 R3 R5 R6 R9 mem_wdata", mem_wdata, ex);
        chk("R5 mem_addr", mem_addr, exp_addr);
        @(posedge clk); #1;
        mem_gnt = 1'b0;
        exp_addr = exp_addr + AW'(SLOTS);
    endtask

    task automatic gnt_out(input logic [WW-1:0] rd);
        @(negedge clk);
        mem_gnt = 1'b1; mem_rdata = rd; #1;
        chk("R7 mem_req/mem_we", {mem_req, mem_we}, 2'b10);
        chk("R7 mem_addr", mem_addr, exp_addr);
        @(posedge clk); #1;
        mem_gnt = 1'b0; mem_rdata = '0;
        exp_addr = exp_addr + AW'(SLOTS);
    endtask

    task automatic read_chk(input logic [5:0] ex);
        @(negedge clk);
        dout_req = 1'b1; #1;
        chk("R7 dout_valid", dout_valid, 1);
        chk("R7 R9 R10 dout_data", dout_data, ex);
        @(posedge clk); #1;
        dout_req = 1'b0;
    endtask

    task automatic read_resp(input logic terr, input logic eor);
        @(negedge clk);
        dout_req = 1'b1; #1;
        chk("R8 dout responses", {dout_valid, dout_terr, dout_eor}, {1'b0, terr, eor});
        @(posedge clk); #1;
        dout_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 reset mem_addr", mem_addr, 0);
        chk("R1 reset mem_req", mem_req, 0);
        chk("R1 reset din_ready", din_ready, 1);

        // R6: end of record with an empty active buffer does nothing
        start(16'd100, 1'b1);
        end_pulse();
        @(negedge clk); #1;
        chk("R6 empty pad no request", mem_req, 0);

        // Table walk: fill, reject, unload order, padding, resync
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_PUT:  put_chk(VEC[i].ch, VEC[i].ex[0]);
                OP_GNT:  gnt_in(VEC[i].ex);
                default: end_pulse();
            endcase
        end
        @(negedge clk); #1;
        chk("R5 all unloaded", mem_req, 0);

        // R1: start in mid-record discards partial data
        put_chk(6'd60, 1); put_chk(6'd61, 1); put_chk(6'd62, 1);
        start(16'd300, 1'b1);
        @(negedge clk); #1;
        chk("R1 start clears", mem_req, 0);
        chk("R1 start address", mem_addr, 300);
        for (int k = 1; k <= 5; k++) put_chk(6'(k), 1);
        gnt_in(w5(6'd1, 6'd2, 6'd3, 6'd4, 6'd5));

        // Output direction
        start(16'd200, 1'b0);
        read_resp(1'b1, 1'b0); // R8 both empty, no stop
        gnt_out(w5(6'd1, 6'd2, 6'd3, 6'd4, 6'o20));
        gnt_out(w5(6'd6, 6'd7, 6'd8, 6'd9, 6'd10));
        @(negedge clk); #1;
        chk("R7 both loaded no request", mem_req, 0);
        read_chk(6'd1); read_chk(6'd2); read_chk(6'd3); read_chk(6'd4);
        read_chk(6'o60); // R10 blank substituted
        @(negedge clk); #1;
        chk("R7 A drained requests load", mem_req, 1);
        gnt_out(w5(6'd11, 6'd12, 6'd13, 6'd14, 6'd15));
        for (int k = 6; k <= 15; k++) read_chk(6'(k));
        @(negedge clk);
        load_stop = 1'b1; #1;
        chk("R7 stop suppresses request", mem_req, 0);
        read_resp(1'b0, 1'b1); // R8 end of record
        @(negedge clk);
        load_stop = 1'b0;
        read_resp(1'b1, 1'b0); // R8 timing error

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule